// File: doc/BRIEF.md
# Two-Wire Scan Packet Serializer

This block sits on the host side of a debug link. It takes a stream of four-wire scan bit requests and turns each one into a packet on a two-wire link. The link has one clock, TCK, and one shared bidirectional data line, TMSC. The data line is split into an output value, an output-enable and an input value, so that a pad at the chip edge can join them.

Each request carries three fields: a TDI bit, a TMS bit and a capture flag. The block runs every request as exactly three TCK cycles:

- The first cycle drives the inverse of TDI.
- The second cycle drives TMS.
- The third cycle is a turnaround. The host releases the line, the target drives TDO back, and the host samples it.

When the capture flag was set, the sampled bit comes back on a response stream.

Requests and responses both use a valid/ready handshake. A request is taken only when the engine is idle and no earlier response is waiting. Therefore, if the response consumer holds `rsp_ready` low, the request side stalls. A request without the capture flag never produces a response. The upstream requester sends each field least-significant bit first. It sets TMS to 0 on every bit except the last bit of a field, which carries TMS 1.

TCK is derived from the system clock with a parameterised half-period. TCK stays low whenever no packet is in flight.

Top module: `tw_scan_serializer`

## Requirements
- R1: After synchronous reset, `tck` is 0, `tmsc_oe` is 0, `rsp_valid` is 0 and `req_ready` is 1.
- R2: Each accepted request produces exactly three rising edges of `tck`, and `tck` is 0 whenever `req_ready` is 1.
- R3: At the first rising edge of a packet, `tmsc_oe` is 1 and `tmsc_o` equals the inverse of the request's TDI bit.
- R4: At the second rising edge of a packet, `tmsc_oe` is 1 and `tmsc_o` equals the request's TMS bit.
- R5: During the third cycle of a packet, `tmsc_oe` is 0. The response bit `rsp_tdo` is the value of `tmsc_i` at that cycle's rising edge.
- R6: `tmsc_o` and `tmsc_oe` change only while `tck` is low, that is, at a falling edge or when idle. They are stable through every high phase.
- R7: A response (`rsp_valid` 1) is issued once per accepted request whose capture flag was 1, and never for one whose flag was 0. While `rsp_ready` is 0, `rsp_valid` and `rsp_tdo` hold.
- R8: `req_ready` is 0 while a packet is in flight and while a response is waiting.
- R9: Every high phase and every low phase of `tck` within a packet lasts `HALF_DIV` system clocks.
- R10: A synchronous reset during a packet drops it. On the next cycle `tck` and `tmsc_oe` are 0, and no response appears for the dropped packet.
- R11: Successive requests keep their order, so a field sent least-significant bit first appears on the line in that order, with the TMS bit carried per request.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request taken this cycle when both are high |
| req_tdi | input | 1 | Logical TDI bit of the request |
| req_tms | input | 1 | Logical TMS bit of the request |
| req_capture | input | 1 | Return the sampled TDO bit when 1 |
| rsp_valid | output | 1 | Response holds a captured bit |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_tdo | output | 1 | Captured TDO bit |
| tck | output | 1 | Link clock, idles low |
| tmsc_o | output | 1 | Data line output value |
| tmsc_oe | output | 1 | Data line output enable |
| tmsc_i | input | 1 | Data line input value |

## Verification
The bench models the line as a wired connection: it reads back the host's own value while `tmsc_oe` is high, and it returns a chosen TDO bit while the line is released. A design that samples in the wrong slot therefore returns the TMS or inverted-TDI bit, not the TDO bit.

The bench walks all four TDI/TMS combinations. A design that forgets the inversion, or swaps the two driven slots, shows the wrong level at the first or second rising edge. The bench also counts rising edges and measures high-phase length, which exposes an off-by-one in the divider or a lost slot.

Holding `rsp_ready` low exposes a design that accepts the next request, or overwrites the waiting bit, under back-pressure. A reset in the middle of the TDO slot catches a design that leaves the clock high, keeps driving the line, or later emits a stale response.

// File: rtl/tw_pkg.sv
package tw_pkg;

  localparam int unsigned SLOTS_PER_BIT = 3;

  typedef enum logic [1:0] {
    SLOT_TDI = 2'd0,
    SLOT_TMS = 2'd1,
    SLOT_TDO = 2'd2
  } slot_e;

  typedef struct packed {
    logic tdi;
    logic tms;
    logic cap;
  } bit_req_t;

endpackage

// File: rtl/tw_tck_gen.sv
module tw_tck_gen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic tck,
  output logic rise_now,
  output logic fall_now
);
  localparam int unsigned CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF_DIV - 1);

  logic [CW-1:0] cnt;
  logic          phase_end;

  assign phase_end = run && (cnt == LAST);
  assign rise_now  = phase_end && !tck;
  assign fall_now  = phase_end && tck;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      tck <= 1'b0;
    end else if (phase_end) begin
      cnt <= '0;
      tck <= !tck;
    end else begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/tw_slot_seq.sv
module tw_slot_seq
  import tw_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     accept,
  input  bit_req_t req,
  input  logic     rise_now,
  input  logic     fall_now,
  output logic     busy,
  output logic     drv,
  output logic     oe,
  output logic     sample_now,
  output logic     done_now,
  output logic     cap
);
  slot_e    slot;
  bit_req_t hold;

  assign sample_now = busy && rise_now && (slot == SLOT_TDO);
  assign done_now   = busy && fall_now && (slot == SLOT_TDO);
  assign cap        = hold.cap;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      slot <= SLOT_TDI;
      hold <= '0;
      drv  <= 1'b0;
      oe   <= 1'b0;
    end else if (!busy) begin
      if (accept) begin
        busy <= 1'b1;
        slot <= SLOT_TDI;
        hold <= req;
        drv  <= !req.tdi;
        oe   <= 1'b1;
      end
    end else if (fall_now) begin
      unique case (slot)
        SLOT_TDI: begin
          slot <= SLOT_TMS;
          drv  <= hold.tms;
        end
        SLOT_TMS: begin
          slot <= SLOT_TDO;
          drv  <= 1'b0;
          oe   <= 1'b0;
        end
        default: begin
          slot <= SLOT_TDI;
          busy <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/tw_rsp_reg.sv
module tw_rsp_reg (
  input  logic clk,
  input  logic rst,
  input  logic sample_now,
  input  logic line_in,
  input  logic done_now,
  input  logic cap,
  input  logic rsp_ready,
  output logic rsp_valid,
  output logic rsp_tdo
);
  logic sampled;

  always_ff @(posedge clk) begin
    if (rst) begin
      sampled   <= 1'b0;
      rsp_valid <= 1'b0;
      rsp_tdo   <= 1'b0;
    end else begin
      if (sample_now) sampled <= line_in;
      if (done_now && cap) begin
        rsp_valid <= 1'b1;
        rsp_tdo   <= sampled;
      end else if (rsp_valid && rsp_ready) begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tw_scan_serializer.sv
module tw_scan_serializer
  import tw_pkg::*;
#(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic req_valid,
  output logic req_ready,
  input  logic req_tdi,
  input  logic req_tms,
  input  logic req_capture,
  output logic rsp_valid,
  input  logic rsp_ready,
  output logic rsp_tdo,
  output logic tck,
  output logic tmsc_o,
  output logic tmsc_oe,
  input  logic tmsc_i
);
  logic     busy, rise_now, fall_now, sample_now, done_now, cap, accept;
  bit_req_t req;

  assign req       = '{tdi: req_tdi, tms: req_tms, cap: req_capture};
  assign req_ready = !busy && !rsp_valid;
  assign accept    = req_valid && req_ready;

  tw_tck_gen #(.HALF_DIV(HALF_DIV)) u_tck (
    .clk(clk), .rst(rst), .run(busy),
    .tck(tck), .rise_now(rise_now), .fall_now(fall_now)
  );

  tw_slot_seq u_seq (
    .clk(clk), .rst(rst), .accept(accept), .req(req),
    .rise_now(rise_now), .fall_now(fall_now),
    .busy(busy), .drv(tmsc_o), .oe(tmsc_oe),
    .sample_now(sample_now), .done_now(done_now), .cap(cap)
  );

  tw_rsp_reg u_rsp (
    .clk(clk), .rst(rst), .sample_now(sample_now), .line_in(tmsc_i),
    .done_now(done_now), .cap(cap), .rsp_ready(rsp_ready),
    .rsp_valid(rsp_valid), .rsp_tdo(rsp_tdo)
  );
endmodule

// File: rtl/tw_scan_serializer_chk.sv
module tw_scan_serializer_chk (
  input logic clk,
  input logic rst,
  input logic req_ready,
  input logic rsp_valid,
  input logic rsp_ready,
  input logic rsp_tdo,
  input logic tck,
  input logic tmsc_o,
  input logic tmsc_oe
);
  AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (rst) req_ready |-> !tck); // R2
  AST_OE_RISE_LOW: assert property (@(posedge clk) disable iff (rst) $rose(tmsc_oe) |-> !tck); // R3
  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (rst) (tck && $past(tck)) |-> ($stable(tmsc_o) && $stable(tmsc_oe))); // R6
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst) (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_tdo))); // R7
  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst) tck |-> !req_ready); // R8
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (!tck && !tmsc_oe && !rsp_valid)); // R10
endmodule

bind tw_scan_serializer tw_scan_serializer_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_valid(rsp_valid),
  .rsp_ready(rsp_ready), .rsp_tdo(rsp_tdo), .tck(tck),
  .tmsc_o(tmsc_o), .tmsc_oe(tmsc_oe)
);

// File: tb/tw_scan_serializer_bench.sv
`timescale 1ns/1ps
module tw_scan_serializer_bench;
  localparam int HALF_DIV = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0, req_tdi = 1'b0, req_tms = 1'b0, req_capture = 1'b0;
  logic rsp_ready = 1'b0;
  logic tdo_drive = 1'b0;
  logic req_ready, rsp_valid, rsp_tdo, tck, tmsc_o, tmsc_oe, tmsc_i;
  int   checks = 0, errors = 0, cycles = 0;

  always #2 clk = !clk;

  assign tmsc_i = tmsc_oe ? tmsc_o : tdo_drive;

  tw_scan_serializer #(.HALF_DIV(HALF_DIV)) u_tw_scan_serializer (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_tdi(req_tdi), .req_tms(req_tms), .req_capture(req_capture),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_tdo(rsp_tdo),
    .tck(tck), .tmsc_o(tmsc_o), .tmsc_oe(tmsc_oe), .tmsc_i(tmsc_i)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 100000);
      finish_run();
    end
  end

  // Issue one request, watch its three slots, check line levels and response.
  task automatic run_packet(input logic tdi, input logic tms, input logic cap,
                            input logic tdo, input logic pop);
    int rises = 0, hi = 0, lo = 0;
    logic prev = 1'b0;
    tdo_drive = tdo;
    @(negedge clk);
    req_valid = 1'b1; req_tdi = tdi; req_tms = tms; req_capture = cap;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < 40 * HALF_DIV; i++) begin
      if (tck && !prev) begin
        if (rises == 0) begin
          check("R3 oe slot1", tmsc_oe, 1);
          check("R3 ~tdi slot1", tmsc_o, !tdi);
        end else if (rises == 1) begin
          check("R4 oe slot2", tmsc_oe, 1);
          check("R4 tms slot2", tmsc_o, tms);
        end else if (rises == 2) begin
          check("R5 oe released slot3", tmsc_oe, 0);
        end
        if (rises > 0 && rises < 3) check("R9 low phase", lo, HALF_DIV);
        rises++;
        lo = 0;
      end
      if (!tck && prev) begin
        check("R9 high phase", hi, HALF_DIV);
        hi = 0;
      end
      if (tck) begin
        hi++;
        check("R8 busy", req_ready, 0);
      end else begin
        lo++;
      end
      if (rises == 3 && !tck) break;
      prev = tck;
      @(negedge clk);
    end
    check("R2 three rises", rises, 3);
    check("R7 rsp on cap", rsp_valid, cap);
    if (cap) check("R5 tdo returned", rsp_tdo, tdo);
    if (cap && pop) begin
      rsp_ready = 1'b1;
      @(negedge clk);
      rsp_ready = 1'b0;
      check("R7 rsp popped", rsp_valid, 0);
    end
  endtask

  task automatic t_reset();
    check("R1 tck", tck, 0);
    check("R1 oe", tmsc_oe, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 req_ready", req_ready, 1);
  endtask

  task automatic t_combos();
    run_packet(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    run_packet(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    run_packet(1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
    run_packet(1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
  endtask

  task automatic t_no_capture();
    run_packet(1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check("R7 no rsp without cap", rsp_valid, 0);
    end
  endtask

  task automatic t_backpressure();
    run_packet(1'b0, 1'b0, 1'b1, 1'b1, 1'b0);
    @(negedge clk);
    req_valid = 1'b1; req_tdi = 1'b1; req_tms = 1'b1; req_capture = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      check("R8 stall on pending rsp", req_ready, 0);
      check("R7 rsp held", rsp_valid, 1);
      check("R7 tdo held", rsp_tdo, 1);
      check("R8 no tck while stalled", tck, 0);
    end
    req_valid = 1'b0;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R7 rsp drained", rsp_valid, 0);
  endtask

  task automatic t_field();
    // 4-bit field 4'b1011 sent LSB first, TMS 1 on the final bit
    logic [3:0] field = 4'b1011;
    logic [3:0] back  = 4'b0110;
    for (int b = 0; b < 4; b++)
      run_packet(field[b], (b == 3), 1'b1, back[b], 1'b1); // R11
  endtask

  task automatic t_reset_mid();
    tdo_drive = 1'b1;
    @(negedge clk);
    req_valid = 1'b1; req_tdi = 1'b0; req_tms = 1'b0; req_capture = 1'b1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    while (tmsc_oe) @(negedge clk);
    while (!tck) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R10 tck low", tck, 0);
    check("R10 oe low", tmsc_oe, 0);
    rst = 1'b0;
    for (int i = 0; i < 5 * HALF_DIV; i++) begin
      @(negedge clk);
      check("R10 no stale rsp", rsp_valid, 0);
      check("R10 idle tck", tck, 0);
    end
    check("R10 ready after reset", req_ready, 1);
    run_packet(1'b1, 1'b0, 1'b1, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_combos();
    t_no_capture();
    t_backpressure();
    t_field();
    t_reset_mid();
    finish_run();
  end
endmodule